// File: doc/BRIEF.md
# Paged Direct Data Address Generator

This block forms the 16-bit data-memory address for an operand fetched in direct mode. The instruction supplies a short 7-bit offset. The block joins that offset to one of two bases. In page mode the base is a 9-bit page register, so the data space is seen as 512 pages of 128 words. In stack mode the base is the stack pointer, and the offset is added to it.

A one-bit mode flag held inside the block picks the base. A separate strobe for memory-mapped register access overrides both bases and always targets page zero. The page register and the mode flag are each loaded through their own load port. A load takes effect on the cycle after it is presented.

The generated address is registered. It appears one clock after the request, together with a valid flag. It holds its value while no request is presented.

Top module: `paged_daddr_gen`

## Requirements
- R1: After reset, `addr_vld` and `addr_out` are 0, and the page register and mode flag are both 0, so the first page-mode request with offset k yields address k.
- R2: With mode flag 0 and `mmr_sel` low, a request yields `addr_out = {page[8:0], ofs_in[6:0]}` (page in bits 15:7, offset in bits 6:0).
- R3: With mode flag 1 and `mmr_sel` low, a request yields `addr_out = (sp_in + ofs_in) mod 65536`.
- R4: When `mmr_sel` is high, a request yields `addr_out = {9'b0, ofs_in}`, whatever the page register, stack pointer and mode flag hold.
- R5: `addr_vld` is high in exactly the cycle after a cycle with `req_vld` high, and low otherwise.
- R6: When `page_ld` and a request occur in the same cycle, the request uses the old page value, and the new value applies from the next request.
- R7: When `mode_ld` and a request occur in the same cycle, the request uses the old mode flag (`mode_val` 1 selects stack mode).
- R8: `addr_out` keeps its value in any cycle after one without a request.
- R9: The offset is unsigned, 0 to 127, in both modes. In stack mode the sum wraps with no saturation, so 0xFFFF + 127 gives 0x007E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| page_ld | input | 1 | Load `page_val` into the page register |
| page_val | input | 9 | New page number |
| mode_ld | input | 1 | Load `mode_val` into the mode flag |
| mode_val | input | 1 | New mode flag: 0 selects page base, 1 selects stack base |
| sp_in | input | 16 | Current stack pointer |
| ofs_in | input | 7 | Direct offset from the instruction |
| mmr_sel | input | 1 | Memory-mapped register access: force page zero |
| req_vld | input | 1 | Address request |
| addr_out | output | 16 | Registered data address |
| addr_vld | output | 1 | `addr_out` was updated by the previous request |

## Verification
The bench sweeps all 512 pages. At each page it issues one request in the same cycle as the page load and another after it. A design that read the page register combinationally would show the new page one request early. A design that dropped a page bit would fail on the high pages. In stack mode the bench steps the stack pointer across the whole range with offsets up to 127, including 0xFFFF + 127. A signed offset or a saturating adder would give the wrong address there. Memory-mapped requests are issued with a nonzero page, in both modes, to catch a design that lets the base leak into the upper nine bits.

// File: rtl/paged_daddr_pkg.sv
package paged_daddr_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned OFS_W  = 7;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  typedef enum logic {
    BASE_PAGE  = 1'b0,
    BASE_STACK = 1'b1
  } base_mode_e;
endpackage

// File: rtl/pdg_rst_sync.sv
module pdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdg_base_regs.sv
module pdg_base_regs
  import paged_daddr_pkg::*;
#(
  parameter int unsigned PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          page_ld,
  input  logic [PW-1:0] page_val,
  input  logic          mode_ld,
  input  logic          mode_val,
  output logic [PW-1:0] page_q,
  output base_mode_e    mode_q
);
  logic [PW-1:0] page_d;
  base_mode_e    mode_d;

  always_comb begin
    page_d = page_q;
    mode_d = mode_q;
    if (page_ld) page_d = page_val;
    if (mode_ld) mode_d = base_mode_e'(mode_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= BASE_PAGE;
    end else begin
      page_q <= page_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/pdg_compose.sv
module pdg_compose
  import paged_daddr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFS_W,
  parameter bit          HAS_MMR = 1'b1
) (
  input  logic [AW-OW-1:0] page_q,
  input  base_mode_e       mode_q,
  input  logic [AW-1:0]    sp_in,
  input  logic [OW-1:0]    ofs_in,
  input  logic             mmr_sel,
  output logic [AW-1:0]    addr_nxt
);
  localparam int unsigned PW = AW - OW;

  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] paged;
  logic [AW-1:0] stacked;
  logic [AW-1:0] based;

  always_comb begin
    ofs_ext = {{PW{1'b0}}, ofs_in};
    paged   = {page_q, ofs_in};
    stacked = sp_in + ofs_ext;
    based   = (mode_q == BASE_STACK) ? stacked : paged;
  end

  generate
    if (HAS_MMR) begin : g_mmr
      always_comb addr_nxt = mmr_sel ? ofs_ext : based;
    end else begin : g_nommr
      always_comb addr_nxt = based;
    end
  endgenerate
endmodule

// File: rtl/paged_daddr_gen.sv
module paged_daddr_gen
  import paged_daddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_ld,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              mode_ld,
  input  logic              mode_val,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic              mmr_sel,
  input  logic              req_vld,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld
);
  logic              rst_s_n;
  logic [PAGE_W-1:0] page_q;
  base_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] addr_d;
  logic              vld_d;

  pdg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pdg_base_regs #(.PW(PAGE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .page_ld  (page_ld),
    .page_val (page_val),
    .mode_ld  (mode_ld),
    .mode_val (mode_val),
    .page_q   (page_q),
    .mode_q   (mode_q)
  );

  pdg_compose #(.AW(ADDR_W), .OW(OFS_W), .HAS_MMR(1'b1)) u_comp (
    .page_q   (page_q),
    .mode_q   (mode_q),
    .sp_in    (sp_in),
    .ofs_in   (ofs_in),
    .mmr_sel  (mmr_sel),
    .addr_nxt (addr_nxt)
  );

  // clock enable on the address register: only a request updates it
  always_comb begin
    addr_d = addr_out;
    if (req_vld) addr_d = addr_nxt;
    vld_d = req_vld;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_out <= addr_d;
      addr_vld <= vld_d;
    end
  end
endmodule

// File: rtl/paged_daddr_chk.sv
module paged_daddr_chk
  import paged_daddr_pkg::*;
(
  input logic              clk,
  input logic              rst_s_n,
  input logic              page_ld,
  input logic [PAGE_W-1:0] page_val,
  input logic              mode_ld,
  input logic              mode_val,
  input logic [ADDR_W-1:0] sp_in,
  input logic [OFS_W-1:0]  ofs_in,
  input logic              mmr_sel,
  input logic              req_vld,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_vld
);
  // shadow of the loadable state, built only from the load ports
  logic [PAGE_W-1:0] sh_page;
  logic              sh_mode;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sh_page <= '0;
      sh_mode <= 1'b0;
    end else begin
      if (page_ld) sh_page <= page_val;
      if (mode_ld) sh_mode <= mode_val;
    end
  end

  a_r5_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_vld |=> addr_vld);
  a_r5_no_vld_when_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_vld |=> !addr_vld);
  a_r4_mmr_page_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_vld && mmr_sel) |=> (addr_out == {{PAGE_W{1'b0}}, $past(ofs_in)}));
  a_r2_page_concat: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_vld && !mmr_sel && !sh_mode) |=> (addr_out == {$past(sh_page), $past(ofs_in)}));
  a_r3_stack_sum: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_vld && !mmr_sel && sh_mode) |=>
      (addr_out == ADDR_W'($past(sp_in) + {{PAGE_W{1'b0}}, $past(ofs_in)})));
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_vld |=> $stable(addr_out));
endmodule

bind paged_daddr_gen paged_daddr_chk u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .page_ld  (page_ld),
  .page_val (page_val),
  .mode_ld  (mode_ld),
  .mode_val (mode_val),
  .sp_in    (sp_in),
  .ofs_in   (ofs_in),
  .mmr_sel  (mmr_sel),
  .req_vld  (req_vld),
  .addr_out (addr_out),
  .addr_vld (addr_vld)
);

// File: tb/tb_paged_daddr_gen.sv
`timescale 1ns/1ps
module tb_paged_daddr_gen;
  logic        clk;
  logic        rst_n;
  logic        page_ld;
  logic [8:0]  page_val;
  logic        mode_ld;
  logic        mode_val;
  logic [15:0] sp_in;
  logic [6:0]  ofs_in;
  logic        mmr_sel;
  logic        req_vld;
  logic [15:0] addr_out;
  logic        addr_vld;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  paged_daddr_gen dut (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_val(page_val),
    .mode_ld(mode_ld), .mode_val(mode_val), .sp_in(sp_in), .ofs_in(ofs_in),
    .mmr_sel(mmr_sel), .req_vld(req_vld), .addr_out(addr_out), .addr_vld(addr_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, then sample just after the capturing edge
  task automatic cyc(input logic req, input logic mmr, input logic pld, input logic [8:0] pv,
                     input logic mld, input logic mv, input logic [15:0] sp, input logic [6:0] ofs);
    @(negedge clk);
    req_vld = req; mmr_sel = mmr; page_ld = pld; page_val = pv;
    mode_ld = mld; mode_val = mv; sp_in = sp; ofs_in = ofs;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0]  prev_page;
    logic [15:0] hold;
    rst_n = 1'b0; req_vld = 0; mmr_sel = 0; page_ld = 0; page_val = 0;
    mode_ld = 0; mode_val = 0; sp_in = 0; ofs_in = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vld", {15'b0, addr_vld}, 16'h0);
    chk("R1 reset addr", addr_out, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 vld after release", {15'b0, addr_vld}, 16'h0);

    cyc(1, 0, 0, 0, 0, 0, 16'hABCD, 7'd5);
    chk("R1 default page", addr_out, 16'h0005);
    chk("R5 vld after req", {15'b0, addr_vld}, 16'h1);

    // page sweep: load plus same-cycle request (old page), then request (new page)
    prev_page = 9'd0;
    for (int p = 0; p < 512; p++) begin
      logic [6:0] o1, o2;
      o1 = 7'((p * 37) % 128);
      o2 = 7'(127 - (p % 128));
      cyc(1, 0, 1, 9'(p), 0, 0, 16'(p * 13), o1);
      chk("R6 same-cycle load uses old page", addr_out, {prev_page, o1});
      cyc(1, 0, 0, 9'h0, 0, 0, 16'hFFFF, o2);
      chk("R2 page concat", addr_out, {9'(p), o2});
      prev_page = 9'(p);
    end

    hold = addr_out;
    cyc(0, 0, 0, 0, 0, 0, 16'h1234, 7'd9);
    chk("R5 no vld when idle", {15'b0, addr_vld}, 16'h0);
    chk("R8 addr holds", addr_out, hold);
    cyc(0, 1, 0, 0, 0, 0, 16'h0, 7'd0);
    chk("R8 addr holds again", addr_out, hold);

    // mode load with same-cycle request uses old (page) mode; page is 511
    cyc(1, 0, 0, 0, 1, 1, 16'h1000, 7'd3);
    chk("R7 same-cycle mode load uses old mode", addr_out, {9'd511, 7'd3});

    for (int i = 0; i < 256; i++) begin
      logic [15:0] sp;
      logic [6:0]  o;
      sp = 16'(i * 4099 + 17);
      o  = 7'((i * 5) % 128);
      cyc(1, 0, 0, 0, 0, 0, sp, o);
      chk("R3 stack sum", addr_out, sp + {9'b0, o});
    end
    cyc(1, 0, 0, 0, 0, 0, 16'hFFFF, 7'd127);
    chk("R9 wrap no saturation", addr_out, 16'h007E);
    cyc(1, 0, 0, 0, 0, 0, 16'h0000, 7'd127);
    chk("R9 offset unsigned", addr_out, 16'h007F);

    // memory-mapped access in stack mode, nonzero page
    for (int o = 0; o < 128; o++) begin
      cyc(1, 1, 0, 0, 0, 0, 16'(16'hF000 + o * 7), 7'(o));
      chk("R4 mmr stack mode", addr_out, {9'b0, 7'(o)});
    end
    cyc(1, 0, 0, 0, 1, 0, 16'h8000, 7'd1);
    chk("R7 mode switch back old mode", addr_out, 16'h8001);
    cyc(1, 0, 0, 0, 0, 0, 16'h8000, 7'd1);
    chk("R2 page mode restored", addr_out, {9'd511, 7'd1});
    for (int o = 0; o < 128; o += 9) begin
      cyc(1, 1, 0, 0, 0, 0, 16'h7777, 7'(o));
      chk("R4 mmr page mode", addr_out, {9'b0, 7'(o)});
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 vld drops", {15'b0, addr_vld}, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule